// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects interrupt events for a small 8-bit microcontroller and presents them to the CPU as a single maskable interrupt line. It watches two asynchronous external interrupt pins, each with its own programmable active edge. It also watches a key-on wakeup event, which can be turned off through an active-low control bit. Single-cycle event pulses from the on-chip peripherals arrive on their own inputs: serial receive, serial transmit, two counters, timer X, timer A, timer 1 and the A-D converter.

Each event sets a sticky flag in one of two request banks. A matching enable bank gates each flag. The OR of all enabled pending flags, blocked while the CPU's interrupt-disable flag is set, is registered and drives the interrupt output. A byte-wide bus with a combinational read path reaches the edge-select, request and enable registers. Software acknowledges a request by writing 0 to its flag.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset the registers at 0x3A, 0x3C, 0x3D, 0x3E and 0x3F all read 0x00 and `irq` is low.
- R2: The edge register at 0x3A holds a select bit for each external pin: bit 0 for pin 0 and bit 1 for pin 1. A select of 0 sets the request on a falling edge of that pin and a select of 1 sets it on a rising edge. The opposite edge sets nothing. The request appears within SYNC_STAGES+2 cycles of the pin change.
- R3: Writing a new edge-select value while the pin is not changing does not set a request.
- R4: Bit 7 of 0x3A is an active-low wakeup control. When it is 0, a `key_evt` pulse sets request bit 4 of 0x3C. When it is 1, the pulse is ignored.
- R5: The bank-1 request register (0x3C) and enable register (0x3E) use these bits: b0 serial receive, b1 serial transmit, b2 pin 0, b3 pin 1, b4 key wakeup, b5 counter 0, b6 counter 1, b7 timer X. Each event sets its flag.
- R6: The bank-2 request register (0x3D) and enable register (0x3F) implement only b0 timer A, b1 A-D conversion and b2 timer 1. Bits 7..3 always read 0, and writes to them are ignored.
- R7: Writing 0 to a request bit clears it. Writing 1 to it leaves it unchanged. Writing an enable register loads its implemented bits.
- R8: An event arriving in the same cycle as a write that clears its flag leaves the flag set.
- R9: `irq` is the registered OR, one cycle late, of all request bits whose enable bit is 1. It is forced low when `cpu_idis` was high in the previous cycle.
- R10: Bits 6..2 of 0x3A always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`; 0 for unmapped addresses |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| key_evt | input | 1 | Key-on wakeup event pulse |
| ser_rx_evt | input | 1 | Serial receive event pulse |
| ser_tx_evt | input | 1 | Serial transmit event pulse |
| cnt0_evt | input | 1 | Counter 0 event pulse |
| cnt1_evt | input | 1 | Counter 1 event pulse |
| tmrx_evt | input | 1 | Timer X event pulse |
| tmra_evt | input | 1 | Timer A event pulse |
| adc_evt | input | 1 | A-D conversion done pulse |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| cpu_idis | input | 1 | CPU interrupt-disable flag |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2, and with the default address map and 8-bit address. The longer synchroniser shows that the pin-to-request latency follows the parameter. The directed pin tests allow a margin that covers any stage count. With the pins held steady, random writes to the edge register exercise select changes without pin activity and check that no request appears. Random bus traffic, random peripheral pulses and random toggling of the CPU disable flag then reach the clear-versus-event collision, the unimplemented-bit masking and the enable gating.

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl #(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] A_EDGE = 'h3A,
  parameter logic [ADDR_W-1:0] A_REQ1 = 'h3C,
  parameter logic [ADDR_W-1:0] A_REQ2 = 'h3D,
  parameter logic [ADDR_W-1:0] A_EN1  = 'h3E,
  parameter logic [ADDR_W-1:0] A_EN2  = 'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        ext_pin,
  input  logic              key_evt,
  input  logic              ser_rx_evt,
  input  logic              ser_tx_evt,
  input  logic              cnt0_evt,
  input  logic              cnt1_evt,
  input  logic              tmrx_evt,
  input  logic              tmra_evt,
  input  logic              adc_evt,
  input  logic              tmr1_evt,
  input  logic              cpu_idis,
  output logic              irq
);
  localparam int CW = 2 * SYNC_STAGES;

  logic [CW-1:0] chain;
  logic [1:0]    pin_s, pin_d, pin_hit, sel;
  logic          wake_off;
  logic [7:0]    req1, en1, ev1, clr1;
  logic [2:0]    req2, en2, ev2, clr2;

  wire wr_edge = bus_wr && bus_addr == A_EDGE;
  wire wr_req1 = bus_wr && bus_addr == A_REQ1;
  wire wr_req2 = bus_wr && bus_addr == A_REQ2;
  wire wr_en1  = bus_wr && bus_addr == A_EN1;
  wire wr_en2  = bus_wr && bus_addr == A_EN2;

  assign pin_s = chain[CW-1 -: 2];

  genvar i;
  generate
    for (i = 0; i < 2; i++) begin : g_edge
      assign pin_hit[i] = sel[i] ? (pin_s[i] & ~pin_d[i]) : (~pin_s[i] & pin_d[i]);
    end
  endgenerate

  assign ev1  = {tmrx_evt, cnt1_evt, cnt0_evt, key_evt & ~wake_off, pin_hit, ser_tx_evt, ser_rx_evt};
  assign ev2  = {tmr1_evt, adc_evt, tmra_evt};
  assign clr1 = wr_req1 ? ~bus_wdata : 8'h00;
  assign clr2 = wr_req2 ? ~bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '0;
      pin_d    <= '0;
      sel      <= '0;
      wake_off <= 1'b0;
      req1     <= '0;
      req2     <= '0;
      en1      <= '0;
      en2      <= '0;
      irq      <= 1'b0;
    end else begin
      chain <= CW'({chain, ext_pin});
      pin_d <= pin_s;
      if (wr_edge) begin
        sel      <= bus_wdata[1:0];
        wake_off <= bus_wdata[7];
      end
      req1 <= (req1 & ~clr1) | ev1;
      req2 <= (req2 & ~clr2) | ev2;
      if (wr_en1) en1 <= bus_wdata;
      if (wr_en2) en2 <= bus_wdata[2:0];
      irq <= (|(req1 & en1) | |(req2 & en2)) & ~cpu_idis;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == A_EDGE)      bus_rdata = {wake_off, 5'b0, sel};
    else if (bus_addr == A_REQ1) bus_rdata = req1;
    else if (bus_addr == A_REQ2) bus_rdata = {5'b0, req2};
    else if (bus_addr == A_EN1)  bus_rdata = en1;
    else if (bus_addr == A_EN2)  bus_rdata = {5'b0, en2};
  end

  // R9
  idis_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_idis |=> !irq);

  // R9
  no_source_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(req1 & en1)) && !(|(req2 & en2))) |=> !irq);

  // R8
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmra_evt |=> req2[0]);

  // R7
  clear_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req2 && !bus_wdata[0] && !tmra_evt) |=> !req2[0]);

  // R4
  wake_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_off && !wr_req1) |=> req1[4] == $past(req1[4]));
endmodule

// File: tb/tb_irq_req_ctrl.sv
module tb_irq_req_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0;
  logic [1:0] ext_pin = 0;
  logic key_evt = 0, ser_rx_evt = 0, ser_tx_evt = 0, cnt0_evt = 0, cnt1_evt = 0;
  logic tmrx_evt = 0, tmra_evt = 0, adc_evt = 0, tmr1_evt = 0, cpu_idis = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_req_ctrl #(.SYNC_STAGES(3)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; {key_evt, ser_rx_evt, ser_tx_evt, cnt0_evt, cnt1_evt} = 0;
    {tmrx_evt, tmra_evt, adc_evt, tmr1_evt} = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); idle(); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, string req, logic [7:0] exp);
    @(negedge clk); idle(); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0; wait_n(2); rst_n = 1;
  endtask

  function automatic logic [7:0] m_read(logic [7:0] a, logic [7:0] e, r1, r2, n1, n2);
    case (a)
      8'h3A: return e;
      8'h3C: return r1;
      8'h3D: return r2;
      8'h3E: return n1;
      8'h3F: return n2;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset values
    rd(8'h3A, "R1", 0); rd(8'h3C, "R1", 0); rd(8'h3D, "R1", 0);
    rd(8'h3E, "R1", 0); rd(8'h3F, "R1", 0);
    chk("R1 irq", irq, 0);

    // R2 falling default: rising edge does nothing, falling sets b2
    ext_pin[0] = 1; wait_n(8);
    rd(8'h3C, "R2 rising ignored", 0);
    ext_pin[0] = 0; wait_n(8);
    rd(8'h3C, "R2 falling sets b2", 8'h04);
    wr(8'h3C, 8'h00);
    rd(8'h3C, "R7 clear", 0);
    // R3 select change with pin steady low
    wr(8'h3A, 8'h03); wait_n(8);
    rd(8'h3C, "R3 select change", 0);
    // R2 pin1 rising with sel=1
    ext_pin[1] = 1; wait_n(8);
    rd(8'h3C, "R2 rising pin1 b3", 8'h08);
    wr(8'h3C, 8'hF7);
    rd(8'h3C, "R7 clear b3", 0);
    // R3 back to falling while pin1 high
    wr(8'h3A, 8'h01); wait_n(8);
    rd(8'h3C, "R3 select change high", 0);
    ext_pin[1] = 0; wait_n(8);
    rd(8'h3C, "R2 falling pin1", 8'h08);
    // R10 unimplemented edge bits
    wr(8'h3A, 8'h7C);
    rd(8'h3A, "R10", 8'h00);
    // R4 wake disabled then enabled
    wr(8'h3C, 8'h00);
    wr(8'h3A, 8'h80);
    @(negedge clk); key_evt = 1; @(negedge clk); key_evt = 0;
    rd(8'h3C, "R4 wake disabled", 0);
    wr(8'h3A, 8'h00);
    @(negedge clk); key_evt = 1; @(negedge clk); key_evt = 0;
    rd(8'h3C, "R4 wake enabled", 8'h10);
    // R5 bank-1 layout
    wr(8'h3C, 8'h00);
    @(negedge clk); ser_rx_evt = 1; cnt1_evt = 1; @(negedge clk); idle();
    rd(8'h3C, "R5 rx b0 cnt1 b6", 8'h41);
    @(negedge clk); ser_tx_evt = 1; cnt0_evt = 1; tmrx_evt = 1; @(negedge clk); idle();
    rd(8'h3C, "R5 tx b1 cnt0 b5 tmx b7", 8'hE3);
    // R7 writing 1 keeps
    wr(8'h3C, 8'hFF);
    rd(8'h3C, "R7 write one keeps", 8'hE3);
    // R6 bank-2
    @(negedge clk); tmra_evt = 1; adc_evt = 1; tmr1_evt = 1; @(negedge clk); idle();
    rd(8'h3D, "R6 bank2 b2..b0", 8'h07);
    wr(8'h3F, 8'hFF);
    rd(8'h3F, "R6 enable2 mask", 8'h07);
    wr(8'h3D, 8'hF8);
    rd(8'h3D, "R6 clear bank2", 8'h00);
    // R8 collision
    @(negedge clk); bus_addr = 8'h3D; bus_wdata = 8'h00; bus_wr = 1; tmra_evt = 1;
    @(negedge clk); idle();
    rd(8'h3D, "R8 event wins", 8'h01);
    // R9 gating by idis
    cpu_idis = 1; wait_n(3);
    chk("R9 idis blocks", irq, 0);
    cpu_idis = 0; wait_n(2);
    chk("R9 enabled pending", irq, 1);
    wr(8'h3F, 8'h00); wait_n(2);
    chk("R9 enable off", irq, 0);

    // random phase with model
    do_reset();
    begin
      logic [7:0] me = 0, mr1 = 0, mr2 = 0, mn1 = 0, mn2 = 0, ev1, ev2;
      logic m_irq = 0;
      logic [7:0] addrs [6] = '{8'h3A, 8'h3C, 8'h3D, 8'h3E, 8'h3F, 8'h55};
      void'($urandom(32'h1234abcd));
      for (int k = 0; k < 4000; k++) begin
        @(negedge clk);
        bus_addr = addrs[$urandom % 6];
        bus_wr = ($urandom % 10) < 3;
        bus_wdata = 8'($urandom);
        {key_evt, ser_rx_evt, ser_tx_evt, cnt0_evt, cnt1_evt} = 5'($urandom & $urandom & $urandom);
        {tmrx_evt, tmra_evt, adc_evt, tmr1_evt} = 4'($urandom & $urandom & $urandom);
        cpu_idis = ($urandom % 4) == 0;
        #1;
        chk("R6 R7 R10 read", bus_rdata, m_read(bus_addr, me, mr1, mr2, mn1, mn2));
        chk("R9 irq", irq, m_irq);
        m_irq = (|((mr1 & mn1) | (mr2 & mn2))) & ~cpu_idis;
        ev1 = {tmrx_evt, cnt1_evt, cnt0_evt, key_evt & ~me[7], 2'b00, ser_tx_evt, ser_rx_evt};
        ev2 = {5'b0, tmr1_evt, adc_evt, tmra_evt};
        if (bus_wr) begin
          case (bus_addr)
            8'h3A: me = bus_wdata & 8'h83;
            8'h3C: mr1 = mr1 & bus_wdata;
            8'h3D: mr2 = mr2 & bus_wdata;
            8'h3E: mn1 = bus_wdata;
            8'h3F: mn2 = bus_wdata & 8'h07;
            default: ;
          endcase
        end
        mr1 = mr1 | ev1;
        mr2 = mr2 | ev2;
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule